// File: doc/BRIEF.md
# Load Extension and Store Lane Steering Unit

This combinational unit sits between a core and a little-endian data memory port whose width is one machine word. For a load it picks the addressed byte or halfword out of the word that memory returns, then widens it to the full word. The widening copies the sign bit or fills with zeros, as a signedness flag selects. For a store it copies the low bits of the source register into every lane that the access could use, and it raises a byte enable only for the lanes that the access writes.

The unit takes the access size, the signedness flag, the low address bits, the read word and the store source. It produces the widened load value, the write word, the byte enables and a flag for an access that is not naturally aligned. When that flag is set the unit writes no byte and returns zero as the load value. Memory and bus handshaking are handled outside the unit.

Top module: `mem_lane_unit`

## Requirements
- R1: A full-width access (size code 2) returns the read word unchanged as the load value when it is aligned.
- R2: A halfword access (size code 1) selects bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1. The unsigned flag set means zero-extension; cleared means sign-extension from bit 15 of the selected half.
- R3: A byte access (size code 0) selects the lane that address bits 1:0 give, with lane 0 at bits 7:0. It is zero-extended when the unsigned flag is set and sign-extended from bit 7 otherwise.
- R4: The write word carries the low 8 source bits copied into all four lanes for a byte store, the low 16 bits copied into both halves for a halfword store, and the source word unchanged for a full store. This holds at every address.
- R5: On an aligned access the byte enables (bit i for lane i) are 4'b1111 for a full store. A halfword store gives 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A byte store gives a one-hot value with bit addr set.
- R6: A halfword access with address bit 0 set, or a full access with either low address bit set, raises the misaligned flag. That access drives all byte enables to 0 and returns a load value of 0.
- R7: The unsigned flag has no effect on full-width loads, on the write word or on the byte enables.
- R8: Size code 3 behaves exactly as size code 2.
- R9: A byte access never raises the misaligned flag, and neither does an access of any size at address offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| size_i | input | 2 | Access size code: 0 byte, 1 halfword, 2 or 3 full word |
| unsigned_i | input | 1 | 1 selects zero-extension of narrow loads |
| addr_lo_i | input | 2 | Low address bits, byte offset within the word |
| rdata_i | input | 32 | Word returned by memory |
| store_src_i | input | 32 | Store source register value |
| load_o | output | 32 | Selected and widened load value |
| wdata_o | output | 32 | Lane-replicated write word |
| byte_en_o | output | 4 | Per-lane write enables |
| misalign_o | output | 1 | Access is not naturally aligned |

## Verification
The unit holds no state, so a fault in its lane selection, extension or enable decode shows at the ports during the same cycle as the stimulus. The bench checks every combination of size code, signedness and offset. Its read words put the selected byte's top bit both set and clear, so a lane index off by one position shows up as a wrong value. An extension of the wrong kind shows up in the upper bits. Any enable raised on a misaligned access would write memory, so the enable vector is checked for all zeros on each of those cases.

// File: rtl/mem_lane_pkg.sv
package mem_lane_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_FULL = 2'd2,
    ACC_ALT  = 2'd3
  } acc_size_e;

  // Size codes 2 and 3 both mean a full-word access.
  function automatic logic acc_is_full(input acc_size_e sz);
    return sz[1];
  endfunction

  function automatic logic acc_is_half(input acc_size_e sz);
    return sz == ACC_HALF;
  endfunction

  function automatic logic acc_is_byte(input acc_size_e sz);
    return sz == ACC_BYTE;
  endfunction

endpackage

// File: rtl/mlu_align_chk.sv
module mlu_align_chk
  import mem_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] addr_lo_i,
  output logic             misalign_o
);

  // Offset bits that must be zero for a naturally aligned access.
  function automatic logic [OFF_W-1:0] align_mask(input acc_size_e sz);
    if (acc_is_byte(sz))      return '0;
    else if (acc_is_half(sz)) return OFF_W'(1);
    else                      return '1;
  endfunction

  logic [OFF_W-1:0] stray_bits;

  assign stray_bits = addr_lo_i & align_mask(size_i);
  assign misalign_o = |stray_bits;

  always_comb begin
    // R9
    if (acc_is_byte(size_i) || addr_lo_i == '0)
      no_byte_misalign_chk: assert (!misalign_o);
  end

endmodule

// File: rtl/mlu_load_extract.sv
module mlu_load_extract
  import mem_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                       size_i,
  input  logic                            unsigned_i,
  input  logic [$clog2(DATA_W/8)-1:0]     addr_lo_i,
  input  logic                            misalign_i,
  input  logic [DATA_W-1:0]               rdata_i,
  output logic [DATA_W-1:0]               load_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HIDX_W = OFF_W - 1;

  function automatic logic [DATA_W-1:0] widen8(input logic [7:0] v, input logic uns);
    return {{(DATA_W-8){~uns & v[7]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] widen16(input logic [15:0] v, input logic uns);
    return {{(DATA_W-16){~uns & v[15]}}, v};
  endfunction

  logic [7:0]  byte_lane [LANES];
  logic [15:0] half_lane [HALVES];
  logic [7:0]  picked_byte;
  logic [15:0] picked_half;
  logic [HIDX_W-1:0] half_idx;

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign byte_lane[g] = rdata_i[8*g +: 8];
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign half_lane[g] = rdata_i[16*g +: 16];
  end

  assign half_idx    = addr_lo_i[OFF_W-1:1];
  assign picked_byte = byte_lane[addr_lo_i];
  assign picked_half = half_lane[half_idx];

  always_comb begin
    if (misalign_i)               load_o = '0;
    else if (acc_is_full(size_i)) load_o = rdata_i;
    else if (acc_is_half(size_i)) load_o = widen16(picked_half, unsigned_i);
    else                          load_o = widen8(picked_byte, unsigned_i);
  end

  always_comb begin
    // R1
    if (acc_is_full(size_i) && !misalign_i)
      full_pass_chk: assert (load_o == rdata_i);
    // R2
    if (acc_is_half(size_i) && !misalign_i && !unsigned_i)
      half_sext_chk: assert (load_o[DATA_W-1:16] == {(DATA_W-16){load_o[15]}});
    // R3
    if (acc_is_byte(size_i) && unsigned_i)
      byte_zext_chk: assert (load_o[DATA_W-1:8] == '0);
  end

endmodule

// File: rtl/mlu_store_steer.sv
module mlu_store_steer
  import mem_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                       size_i,
  input  logic [$clog2(DATA_W/8)-1:0]     addr_lo_i,
  input  logic                            misalign_i,
  input  logic [DATA_W-1:0]               store_src_i,
  output logic [DATA_W-1:0]               wdata_o,
  output logic [DATA_W/8-1:0]             byte_en_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HIDX_W = OFF_W - 1;

  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;
  logic [LANES-1:0]  lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_rep_b
    assign rep_byte[8*g +: 8] = store_src_i[7:0];
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_rep_h
    assign rep_half[16*g +: 16] = store_src_i[15:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_en
    assign lane_hit[g] = !misalign_i &&
      (acc_is_full(size_i) ||
       (acc_is_half(size_i) && addr_lo_i[OFF_W-1:1] == HIDX_W'(g / 2)) ||
       (acc_is_byte(size_i) && addr_lo_i == OFF_W'(g)));
  end

  assign byte_en_o = lane_hit;

  always_comb begin
    if (acc_is_full(size_i))      wdata_o = store_src_i;
    else if (acc_is_half(size_i)) wdata_o = rep_half;
    else                          wdata_o = rep_byte;
  end

  always_comb begin
    // R6
    if (misalign_i)
      no_write_misalign_chk: assert (byte_en_o == '0);
    // R5
    if (acc_is_byte(size_i))
      byte_onehot_chk: assert ($onehot(byte_en_o));
    // R5
    if (acc_is_half(size_i) && !misalign_i)
      half_pair_chk: assert ($countones(byte_en_o) == 2);
  end

endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
  import mem_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] store_src_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  byte_en_o,
  output logic              misalign_o
);

  acc_size_e acc_size;
  logic      access_bad;

  assign acc_size = acc_size_e'(size_i);

  mlu_align_chk #(.OFF_W(OFF_W)) i_align (
    .size_i     (acc_size),
    .addr_lo_i  (addr_lo_i),
    .misalign_o (access_bad)
  );

  mlu_load_extract #(.DATA_W(DATA_W)) i_load (
    .size_i     (acc_size),
    .unsigned_i (unsigned_i),
    .addr_lo_i  (addr_lo_i),
    .misalign_i (access_bad),
    .rdata_i    (rdata_i),
    .load_o     (load_o)
  );

  mlu_store_steer #(.DATA_W(DATA_W)) i_store (
    .size_i      (acc_size),
    .addr_lo_i   (addr_lo_i),
    .misalign_i  (access_bad),
    .store_src_i (store_src_i),
    .wdata_o     (wdata_o),
    .byte_en_o   (byte_en_o)
  );

  assign misalign_o = access_bad;

  always_comb begin
    // R6
    if (access_bad)
      zero_load_misalign_chk: assert (load_o == '0);
  end

endmodule

// File: tb/test_mem_lane_unit.sv
module test_mem_lane_unit;

  logic        clk = 1'b0;
  logic [1:0]  size_i;
  logic        unsigned_i;
  logic [1:0]  addr_lo_i;
  logic [31:0] rdata_i;
  logic [31:0] store_src_i;
  logic [31:0] load_o;
  logic [31:0] wdata_o;
  logic [3:0]  byte_en_o;
  logic        misalign_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mem_lane_unit i_mem_lane_unit (
    .size_i      (size_i),
    .unsigned_i  (unsigned_i),
    .addr_lo_i   (addr_lo_i),
    .rdata_i     (rdata_i),
    .store_src_i (store_src_i),
    .load_o      (load_o),
    .wdata_o     (wdata_o),
    .byte_en_o   (byte_en_o),
    .misalign_o  (misalign_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s size=%0d uns=%0d off=%0d got=%h exp=%h",
               tag, size_i, unsigned_i, addr_lo_i, got, exp);
    end
  endtask

  logic [31:0] pats [6] = '{32'h8070F00F, 32'h7F80017E, 32'hFFFFFFFF,
                             32'h00000000, 32'h12834_5F6 >> 4, 32'h01FF80FE};

  initial begin
    size_i = 0; unsigned_i = 0; addr_lo_i = 0; rdata_i = 0; store_src_i = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++)
          for (int p = 0; p < 6; p++) begin
            logic [31:0] r, d, exp_ld, exp_wd, sel;
            logic [3:0]  exp_be;
            bit full, mis;
            @(posedge clk);
            #1;
            size_i = 2'(sz); unsigned_i = u[0]; addr_lo_i = 2'(a);
            r = pats[p]; d = pats[(p + 3) % 6] ^ 32'h5A5A0000;
            rdata_i = r; store_src_i = d;
            full = (sz >= 2);
            mis  = (sz == 1 && (a % 2) == 1) || (full && a != 0);
            if (mis) exp_ld = 0;
            else if (full) exp_ld = r;
            else if (sz == 1) begin
              sel = (r >> ((a / 2) * 16)) & 32'hFFFF;
              exp_ld = (u == 0 && sel[15]) ? (sel | 32'hFFFF0000) : sel;
            end else begin
              sel = (r >> (a * 8)) & 32'hFF;
              exp_ld = (u == 0 && sel[7]) ? (sel | 32'hFFFFFF00) : sel;
            end
            if (full) exp_wd = d;
            else if (sz == 1) exp_wd = (d & 32'hFFFF) * 32'h00010001;
            else exp_wd = (d & 32'hFF) * 32'h01010101;
            if (mis) exp_be = 0;
            else if (full) exp_be = 4'hF;
            else if (sz == 1) exp_be = (a >= 2) ? 4'hC : 4'h3;
            else exp_be = 4'(1 << a);
            @(negedge clk);
            // R6 R9 misaligned flag
            check(mis ? "R6 flag" : "R9 flag", {31'b0, misalign_o}, {31'b0, mis});
            // R1 R2 R3 R6 R7 R8 load value
            check(mis ? "R6 load" : (sz == 3 ? "R8 load" : (full ? (u ? "R7 load" : "R1 load")
                  : (sz == 1 ? "R2 load" : "R3 load"))), load_o, exp_ld);
            // R4 R7 write word
            check(u ? "R7 wdata" : (sz == 3 ? "R8 wdata" : "R4 wdata"), wdata_o, exp_wd);
            // R5 R6 byte enables
            check(mis ? "R6 byte_en" : (u ? "R7 byte_en" : "R5 byte_en"),
                  {28'b0, byte_en_o}, {28'b0, exp_be});
          end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule